// File: doc/BRIEF.md
# Page ECC Parity Generator

This block computes a single-error-correcting Hamming parity code over the data bytes of a NAND page as they stream past, whether they are on their way to the flash or coming back from it. Bytes are taken in fixed chunks of 256. At the end of each chunk the block delivers a 21-bit parity word. The word holds 6 column-parity bits, which locate the bit inside a byte, and 15 line-parity bits, which locate the byte inside the chunk. A one-cycle strobe marks each new word.

Firmware or a transfer engine drives the byte stream. A configuration input enables the generator, and a per-byte flag marks spare-area bytes so that they are left out of the code. A single-cycle clear input discards any partly accumulated chunk before a new page starts. For each word the block also gives the 24-bit form in which the code is kept in the spare area: the word shifted left by two places, inverted and limited to 24 bits. After every completed chunk it sends that form out as three bytes, most significant byte first, so that it can be written next to the page data. Locating and correcting an error on read-back is done downstream, from the difference between a stored code and a freshly computed one.

Top module: `ecc_page_par`

## Requirements
- R1: While reset is asserted and after it, until the first chunk completes, par_word is 0, par_vld and spr_vld are 0, and par_store is 24'hFFFFFF.
- R2: Column field par_word[5:0]: for k = 0..2, bit 2k is the XOR of every data bit in the chunk whose bit position within its byte has bit k equal to 0, and bit 2k+1 is the XOR of those whose position has bit k equal to 1.
- R3: Line field par_word[20:6]: the byte index counts accepted bytes from 0 to 255. For k = 0..6, bit 6+2k is the XOR of all bits of the bytes whose index has bit k equal to 0, and bit 7+2k the same over the bytes whose index has bit k equal to 1. Bit 20 is the XOR over the bytes whose index has bit 7 equal to 1.
- R4: A byte is accepted on a clock edge when in_vld and cfg_ecc_en are 1 and in_spare and ctl_ecc_clr are 0. On the edge that accepts the 256th byte, par_word is loaded and par_vld goes high for exactly one cycle. The next accepted byte starts a new chunk at index 0, with no carry-over.
- R5: A byte presented while cfg_ecc_en is 0 contributes nothing and does not advance the byte index.
- R6: A byte presented with in_spare = 1 contributes nothing and does not advance the byte index.
- R7: ctl_ecc_clr = 1 on an edge resets the byte index and the partial parity to zero, sets par_word to 0 and stops any serialization in progress. It takes priority over a byte presented on the same edge, and that byte is dropped.
- R8: par_store equals bitwise NOT of (par_word shifted left by 2), limited to 24 bits. So bit 23 and bits [1:0] are always 1.
- R9: In the three cycles that follow a par_vld cycle, spr_vld is 1 and spr_byte carries par_store[23:16], then [15:8], then [7:0]. At all other times spr_vld is 0.
- R10: par_word holds its value from one completed chunk to the next unless ctl_ecc_clr is applied.
- R11: When a single data bit of a chunk is flipped, the XOR of the two parity words has exactly one bit set in each complementary pair. The odd-pair bits, with bit 20 taken as the most significant, spell out the byte index and the bit position of the flipped bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ecc_en | input | 1 | Generator enable; bytes are ignored while low |
| ctl_ecc_clr | input | 1 | One-cycle clear of partial parity, byte index and result |
| in_vld | input | 1 | A byte is presented on in_byte |
| in_spare | input | 1 | The presented byte belongs to the spare area and is excluded |
| in_byte | input | 8 | Data byte |
| par_vld | output | 1 | One-cycle strobe: par_word has just been loaded |
| par_word | output | 21 | Parity of the last chunk: column [5:0], line [20:6] |
| par_store | output | 24 | Spare-area form of par_word |
| spr_vld | output | 1 | A byte of the spare-area form is on spr_byte |
| spr_byte | output | 8 | Spare-area form, most significant byte first |

## Verification
The bench goes after the ends of the chunk: a lone bit at byte 0, bit 0 and a lone bit at byte 255, bit 7. A design with swapped pair members, a shifted field or a lost top line bit would give a word other than 0x55555 or 0x1AAAAA. It mixes disabled and spare bytes into a chunk, so a design that counted or folded them would end the chunk early or produce a different word. It applies a clear together with a byte and again on the very cycle the serializer would load, so a design that let the byte through or kept sending stale spare bytes would be caught by the per-clock model. A one-bit-flip pair of chunks checks that the syndrome decodes to the flipped position, which a design with a mis-ordered line field would fail.

// File: rtl/ecc_par_pkg.sv
package ecc_par_pkg;

   // Width of one side of a complementary parity pair set over n positions
   function automatic int pair_bits(input int n);
      return 2 * $clog2(n);
   endfunction

   // True when n is a power of two and at least two
   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   localparam int NAND_BYTE_W = 8;

endpackage

// File: rtl/ecc_col_acc.sv
// Column parity: folds every accepted byte into one register, then derives
// the complementary pairs over bit position from the folded byte.
module ecc_col_acc #(
   parameter int DATA_W = 8,
   localparam int BIT_IDX_W = $clog2(DATA_W),
   localparam int COL_W = 2 * BIT_IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              restart,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   output logic [COL_W-1:0]  col_next
);

   logic [DATA_W-1:0] fold_q;
   logic [DATA_W-1:0] fold_d;

   assign fold_d = take ? (fold_q ^ din) : fold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fold_q <= '0;
      end else if (clr || restart) begin
         fold_q <= '0;
      end else begin
         fold_q <= fold_d;
      end
   end

   // One pair per bit of the bit-position index
   for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_col_pair
      logic lo_par;
      logic hi_par;
      always_comb begin
         lo_par = 1'b0;
         hi_par = 1'b0;
         for (int j = 0; j < DATA_W; j++) begin
            if (((j >> k) & 1) == 1) hi_par = hi_par ^ fold_d[j];
            else                     lo_par = lo_par ^ fold_d[j];
         end
      end
      assign col_next[2*k]   = lo_par;
      assign col_next[2*k+1] = hi_par;
   end

endmodule

// File: rtl/ecc_line_acc.sv
// Line parity: counts the byte index inside the chunk and steers each byte's
// row parity into the even or odd member of every index-bit pair. The even
// member of the top index bit is redundant and is not built.
module ecc_line_acc #(
   parameter int IDX_W = 8,
   localparam int LINE_W = 2 * IDX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic              row_par,
   output logic              last,
   output logic [LINE_W-1:0] line_next
);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-2:0] ev_q, ev_d;
   logic [IDX_W-1:0] od_q, od_d;
   logic             hit;

   assign hit  = take & row_par;
   assign last = take & (&idx_q);

   for (genvar k = 0; k < IDX_W; k++) begin : g_line_pair
      assign od_d[k] = od_q[k] ^ (hit & idx_q[k]);
      if (k < IDX_W - 1) begin : g_both
         assign ev_d[k]          = ev_q[k] ^ (hit & ~idx_q[k]);
         assign line_next[2*k]   = ev_d[k];
         assign line_next[2*k+1] = od_d[k];
      end else begin : g_top
         assign line_next[LINE_W-1] = od_d[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         ev_q  <= '0;
         od_q  <= '0;
      end else if (clr || last) begin
         idx_q <= '0;
         ev_q  <= '0;
         od_q  <= '0;
      end else if (take) begin
         idx_q <= idx_q + 1'b1;
         ev_q  <= ev_d;
         od_q  <= od_d;
      end
   end

endmodule

// File: rtl/ecc_spare_ser.sv
// Sends the spare-area form out byte by byte, most significant byte first.
module ecc_spare_ser #(
   parameter int STORE_W = 24,
   parameter int BYTE_W = 8,
   localparam int NBYTES = STORE_W / BYTE_W,
   localparam int CNT_W = $clog2(NBYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               abort,
   input  logic               load,
   input  logic [STORE_W-1:0] word,
   output logic               out_vld,
   output logic [BYTE_W-1:0]  out_byte
);

   logic [STORE_W-1:0] sh_q;
   logic [CNT_W-1:0]   cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (abort) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= word;
         cnt_q <= CNT_W'(NBYTES);
      end else if (cnt_q != '0) begin
         sh_q  <= sh_q << BYTE_W;
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign out_vld  = (cnt_q != '0);
   assign out_byte = sh_q[STORE_W-1 -: BYTE_W];

endmodule

// File: rtl/ecc_page_par.sv
module ecc_page_par #(
   parameter int DATA_W = ecc_par_pkg::NAND_BYTE_W,
   parameter int CHUNK_BYTES = 256,
   parameter int STORE_W = 24,
   parameter int STORE_SHIFT = 2,
   localparam int IDX_W = $clog2(CHUNK_BYTES),
   localparam int COL_W = ecc_par_pkg::pair_bits(DATA_W),
   localparam int LINE_W = ecc_par_pkg::pair_bits(CHUNK_BYTES) - 1,
   localparam int WORD_W = COL_W + LINE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_ecc_en,
   input  logic               ctl_ecc_clr,
   input  logic               in_vld,
   input  logic               in_spare,
   input  logic [DATA_W-1:0]  in_byte,
   output logic               par_vld,
   output logic [WORD_W-1:0]  par_word,
   output logic [STORE_W-1:0] par_store,
   output logic               spr_vld,
   output logic [DATA_W-1:0]  spr_byte
);

   // Elaboration-time parameter checks
   if (!ecc_par_pkg::is_pow2(DATA_W)) begin : g_bad_data_w
      $error("DATA_W must be a power of two");
   end
   if (!ecc_par_pkg::is_pow2(CHUNK_BYTES) || CHUNK_BYTES < 4) begin : g_bad_chunk
      $error("CHUNK_BYTES must be a power of two of at least 4");
   end
   if (STORE_W < WORD_W + STORE_SHIFT) begin : g_bad_store_w
      $error("STORE_W too narrow for the shifted parity word");
   end
   if ((STORE_W % DATA_W) != 0) begin : g_bad_store_mul
      $error("STORE_W must be a whole number of bytes");
   end

   logic              take;
   logic              last;
   logic              row_par;
   logic [COL_W-1:0]  col_next;
   logic [LINE_W-1:0] line_next;

   assign take    = in_vld & cfg_ecc_en & ~in_spare & ~ctl_ecc_clr;
   assign row_par = ^in_byte;

   ecc_col_acc #(.DATA_W(DATA_W)) col_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ctl_ecc_clr),
      .restart  (last),
      .take     (take),
      .din      (in_byte),
      .col_next (col_next)
   );

   ecc_line_acc #(.IDX_W(IDX_W)) line_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ctl_ecc_clr),
      .take      (take),
      .row_par   (row_par),
      .last      (last),
      .line_next (line_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_word <= '0;
         par_vld  <= 1'b0;
      end else if (ctl_ecc_clr) begin
         par_word <= '0;
         par_vld  <= 1'b0;
      end else begin
         par_vld <= last;
         if (last) par_word <= {line_next, col_next};
      end
   end

   assign par_store = ~(STORE_W'(par_word) << STORE_SHIFT);

   ecc_spare_ser #(.STORE_W(STORE_W), .BYTE_W(DATA_W)) ser_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort    (ctl_ecc_clr),
      .load     (par_vld),
      .word     (par_store),
      .out_vld  (spr_vld),
      .out_byte (spr_byte)
   );

endmodule

// File: rtl/ecc_page_par_chk.sv
module ecc_page_par_chk #(
   parameter int WORD_W = 21,
   parameter int STORE_W = 24,
   parameter int DATA_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_ecc_en,
   input logic               ctl_ecc_clr,
   input logic               in_spare,
   input logic               par_vld,
   input logic [WORD_W-1:0]  par_word,
   input logic [STORE_W-1:0] par_store,
   input logic               spr_vld,
   input logic [DATA_W-1:0]  spr_byte
);

   // R4
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_vld |=> !par_vld);

   // R5
   en_low_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ecc_en |=> !par_vld);

   // R6
   spare_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_spare |=> !par_vld);

   // R7
   clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_ecc_clr |=> (par_word == '0 && !par_vld && !spr_vld));

   // R9
   ser_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_vld && !ctl_ecc_clr) |=> (spr_vld && spr_byte == $past(par_store[STORE_W-1 -: DATA_W])));

   // R9
   ser_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spr_vld) |-> $past(par_vld));

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_ecc_clr |=> (par_vld || $stable(par_word)));

endmodule

bind ecc_page_par ecc_page_par_chk #(
   .WORD_W (WORD_W),
   .STORE_W(STORE_W),
   .DATA_W (DATA_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_ecc_en (cfg_ecc_en),
   .ctl_ecc_clr(ctl_ecc_clr),
   .in_spare   (in_spare),
   .par_vld    (par_vld),
   .par_word   (par_word),
   .par_store  (par_store),
   .spr_vld    (spr_vld),
   .spr_byte   (spr_byte)
);

// File: tb/ecc_page_par_tb_top.sv
`timescale 1ns/1ps
module ecc_page_par_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_ecc_en = 1'b0;
   logic        ctl_ecc_clr = 1'b0;
   logic        in_vld = 1'b0;
   logic        in_spare = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        par_vld;
   logic [20:0] par_word;
   logic [23:0] par_store;
   logic        spr_vld;
   logic [7:0]  spr_byte;

   always #4 clk = ~clk;

   ecc_page_par dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_ecc_en(cfg_ecc_en), .ctl_ecc_clr(ctl_ecc_clr),
      .in_vld(in_vld), .in_spare(in_spare), .in_byte(in_byte),
      .par_vld(par_vld), .par_word(par_word), .par_store(par_store),
      .spr_vld(spr_vld), .spr_byte(spr_byte)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [7:0]  mq[$];
   logic [7:0]  mser[$];
   logic [20:0] m_word = '0;
   logic        m_vld = 1'b0;

   function automatic logic [20:0] ref_code();
      logic [5:0]  cp = '0;
      logic [14:0] lp = '0;
      for (int i = 0; i < 256; i++) begin
         logic [7:0] b = mq[i];
         logic rp = ^b;
         for (int k = 0; k < 7; k++) begin
            if (((i >> k) & 1) == 1) lp[2*k+1] ^= rp;
            else                     lp[2*k]   ^= rp;
         end
         if (i >= 128) lp[14] ^= rp;
         for (int j = 0; j < 8; j++) begin
            if (b[j]) begin
               for (int k = 0; k < 3; k++) begin
                  if (((j >> k) & 1) == 1) cp[2*k+1] ^= 1'b1;
                  else                     cp[2*k]   ^= 1'b1;
               end
            end
         end
      end
      return {lp, cp};
   endfunction

   function automatic logic [23:0] ref_store(input logic [20:0] w);
      logic [31:0] t;
      t = ~({11'b0, w} << 2);
      return t[23:0];
   endfunction

   always @(posedge clk) begin : model
      logic        old_vld;
      logic [23:0] st;
      old_vld = m_vld;
      if (!rst_n) begin
         mq.delete(); mser.delete(); m_word = '0; m_vld = 1'b0;
      end else begin
         if (ctl_ecc_clr) mser.delete();
         else if (old_vld) begin
            st = ref_store(m_word);
            mser.delete();
            mser.push_back(st[23:16]); mser.push_back(st[15:8]); mser.push_back(st[7:0]);
         end else if (mser.size() > 0) void'(mser.pop_front());
         m_vld = 1'b0;
         if (ctl_ecc_clr) begin
            mq.delete(); m_word = '0;
         end else if (in_vld && cfg_ecc_en && !in_spare) begin
            mq.push_back(in_byte);
            if (mq.size() == 256) begin
               m_word = ref_code(); m_vld = 1'b1; mq.delete();
            end
         end
      end
   end

   // ---------------- per-clock comparison and capture ----------------
   logic [20:0] last_word = '0;
   logic [7:0]  cap[$];

   always @(negedge clk) begin
      check(par_vld === m_vld, "R4 par_vld", 32'(par_vld), 32'(m_vld));
      check(par_word === m_word, "R3 par_word", 32'(par_word), 32'(m_word));
      check(par_store === ref_store(m_word), "R8 par_store", 32'(par_store), 32'(ref_store(m_word)));
      check(spr_vld === (mser.size() > 0), "R9 spr_vld", 32'(spr_vld), 32'(mser.size() > 0));
      if (mser.size() > 0)
         check(spr_byte === mser[0], "R9 spr_byte", 32'(spr_byte), 32'(mser[0]));
      if (par_vld) last_word = par_word;
      if (spr_vld) cap.push_back(spr_byte);
   end

   // ---------------- stimulus helpers ----------------
   logic [7:0] pat [256];
   logic [31:0] seed = 32'h1357_9bdf;

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x = s;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      return x;
   endfunction

   task automatic step(input logic v, input logic [7:0] d, input logic en,
                       input logic sp, input logic cl);
      @(negedge clk);
      in_vld = v; in_byte = d; cfg_ecc_en = en; in_spare = sp; ctl_ecc_clr = cl;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
   endtask

   // junk_mode: 0 none, 1 disabled bytes, 2 spare bytes, interleaved every 16
   task automatic send_chunk(input int junk_mode);
      for (int i = 0; i < 256; i++) begin
         if (junk_mode == 1 && (i % 16) == 3) step(1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
         if (junk_mode == 2 && (i % 16) == 5) step(1'b1, 8'h3C, 1'b1, 1'b1, 1'b0);
         step(1'b1, pat[i], 1'b1, 1'b0, 1'b0);
      end
   endtask

   task automatic fill_zero();
      for (int i = 0; i < 256; i++) pat[i] = 8'h00;
   endtask

   task automatic fill_rand();
      for (int i = 0; i < 256; i++) begin
         seed = nxt(seed);
         pat[i] = seed[7:0];
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 60000) begin
         total++; bad++;
         $display("FAIL R4 watchdog actual=%0d expected<%0d", cyc, 60000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin : main
      logic [20:0] wa, wb, syn;
      logic [7:0]  idx_d;
      logic [2:0]  pos_d;
      bit          pairs_ok;

      repeat (3) @(negedge clk);
      // R1 reset state
      check(par_word == 21'h0 && !par_vld, "R1 reset word/vld", 32'(par_word), 32'h0);
      check(par_store == 24'hFFFFFF, "R1 reset store", 32'(par_store), 32'hFFFFFF);
      check(!spr_vld, "R1 reset spr_vld", 32'(spr_vld), 32'h0);
      rst_n = 1'b1;
      idle(2);

      // R2 R3 R8 R9: lone bit 0 in byte 0
      fill_zero(); pat[0] = 8'h01;
      cap.delete();
      send_chunk(0); idle(6);
      check(last_word[5:0] == 6'h15, "R2 column lone bit0", 32'(last_word[5:0]), 32'h15);
      check(last_word[20:6] == 15'h1555, "R3 line byte0", 32'(last_word[20:6]), 32'h1555);
      check(par_store == 24'hEAAAAB, "R8 store form", 32'(par_store), 32'hEAAAAB);
      check(cap.size() == 3 && cap[0] == 8'hEA && cap[1] == 8'hAA && cap[2] == 8'hAB,
            "R9 spare bytes msb first", {cap.size() > 0 ? cap[0] : 8'h00, 24'h0}, 32'hEA000000);

      // R5 R2 R3: lone bit 7 in byte 255, with disabled junk interleaved
      fill_zero(); pat[255] = 8'h80;
      send_chunk(1); idle(6);
      check(last_word == 21'h1AAAAA, "R5 disabled bytes ignored", 32'(last_word), 32'h1AAAAA);
      check(last_word[5:0] == 6'h2A, "R2 column lone bit7", 32'(last_word[5:0]), 32'h2A);
      check(last_word[20] == 1'b1, "R3 top line bit", 32'(last_word[20]), 32'h1);

      // R10: no change while disabled bytes stream in
      for (int i = 0; i < 20; i++) step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
      idle(2);
      check(par_word == 21'h1AAAAA, "R10 word held", 32'(par_word), 32'h1AAAAA);

      // R6: spare bytes interleaved
      fill_zero(); pat[0] = 8'h01;
      send_chunk(2); idle(6);
      check(last_word == 21'h55555, "R6 spare bytes ignored", 32'(last_word), 32'h55555);

      // R4: random chunks back to back, no carry-over
      fill_rand(); send_chunk(0);
      fill_zero(); pat[255] = 8'h80; send_chunk(0); idle(4);
      check(last_word == 21'h1AAAAA, "R4 restart after chunk", 32'(last_word), 32'h1AAAAA);

      // R7: clear mid-chunk with a byte on the same edge
      fill_rand();
      for (int i = 0; i < 100; i++) step(1'b1, pat[i], 1'b1, 1'b0, 1'b0);
      step(1'b1, 8'hFF, 1'b1, 1'b0, 1'b1);
      step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      check(par_word == 21'h0, "R7 clear zeroes word", 32'(par_word), 32'h0);
      fill_zero(); pat[0] = 8'h01;
      send_chunk(0); idle(6);
      check(last_word == 21'h55555, "R7 fresh chunk after clear", 32'(last_word), 32'h55555);

      // R7: clear on the cycle the serializer would load
      fill_rand(); send_chunk(0);
      step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
      step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      check(!spr_vld && par_word == 21'h0, "R7 clear aborts serializer", 32'(spr_vld), 32'h0);
      idle(4);

      // R11: single-bit flip syndrome
      fill_rand(); send_chunk(0); idle(4); wa = last_word;
      pat[77] = pat[77] ^ 8'h20;
      send_chunk(0); idle(4); wb = last_word;
      syn = wa ^ wb;
      pairs_ok = 1'b1;
      for (int k = 0; k < 3; k++) if ((syn[2*k] ^ syn[2*k+1]) != 1'b1) pairs_ok = 1'b0;
      for (int k = 0; k < 7; k++) if ((syn[6+2*k] ^ syn[7+2*k]) != 1'b1) pairs_ok = 1'b0;
      check(pairs_ok, "R11 one bit per pair", 32'(syn), 32'h0);
      idx_d = {syn[20], syn[19], syn[17], syn[15], syn[13], syn[11], syn[9], syn[7]};
      pos_d = {syn[5], syn[3], syn[1]};
      check(idx_d == 8'd77, "R11 byte index", 32'(idx_d), 32'd77);
      check(pos_d == 3'd5, "R11 bit position", 32'(pos_d), 32'd5);

      idle(4);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule